// File: doc/BRIEF.md
# Supervisory Watchdog with Restart-Cause Flag

This block watches for a periodic service strobe from the host processor. If the strobe does not arrive within a selectable window, the block raises a reset pulse. The window is chosen by a 2-bit select field. The field is held in a nonvolatile status register outside this block and changes only through that register's write operation. Three select codes give a long, a medium and a short window, in the ratio 1.4 : 0.6 : 0.2. The fourth code turns the watchdog off. Windows are counted in ticks of a prescaled time base, so the real-time lengths are set by parameters.

The block also holds a volatile flag that software sets and clears with two dedicated strobes. Only a power-on reset clears the flag, and the block's own reset pulse leaves it alone. After a restart, software reads the flag to tell a watchdog restart from a power failure: if it set the flag before the failure, the flag is still 1 after a watchdog restart and 0 after power returns.

Top module: `wdg_supervisor`

## Requirements
- R1: While `por_n` is low and after it is released, `rst_out` is 0 and `cause_flag` is 0.
- R2: Select code 2'b00 gives a window of `T_LONG` ticks, 2'b01 gives `T_MID` ticks and 2'b10 gives `T_SHORT` ticks. One tick is `PRESCALE` clock cycles. `rst_out` rises at the clock edge that comes exactly window×`PRESCALE` edges after the most recent restart edge.
- R3: Select code 2'b11 disables the watchdog. While it is applied, `rst_out` never rises and no time builds up toward a window.
- R4: A `kick` sampled high while `rst_out` is low restarts the window count from zero at that edge.
- R5: A change of the select field seen at a clock edge while `rst_out` is low restarts the count from zero at that edge. Counting then uses the new window.
- R6: Each reset pulse lasts exactly `RST_TICKS`×`PRESCALE` cycles. `kick` and changes of the select field during the pulse do not shorten or lengthen it.
- R7: At the edge where the pulse ends, counting starts again from zero. The next pulse rises window×`PRESCALE` edges later unless the host intervenes.
- R8: `flag_set` sampled high makes `cause_flag` 1 at the next edge. `flag_clr` alone makes it 0. When both are high in the same cycle, the set wins.
- R9: `cause_flag` changes only through `flag_set`, `flag_clr` or a low `por_n`. A watchdog reset pulse leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| kick | input | 1 | Service strobe from the host |
| wd_sel | input | 2 | Window select from the status register |
| flag_set | input | 1 | Set strobe for the software flag |
| flag_clr | input | 1 | Clear strobe for the software flag |
| rst_out | output | 1 | Watchdog reset pulse, active high |
| cause_flag | output | 1 | Software flag that survives watchdog resets |

## Verification
The hardest state to reach from the ports is a reset pulse that is already running when the host does something: a kick arrives, or the select field is rewritten. Either event would restart the count if the pulse were not running. The stimulus lets a short window expire, drives a kick and then a select change while the pulse is high, and measures the pulse length to the cycle. It then measures the time from the falling edge to the next rise, which shows that the count restarted from zero. The flag is set before an expiry and read after the pulse, then cleared only by a power-on reset, so the two restart causes are shown apart.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;

  localparam logic [1:0] SEL_OFF = 2'b11;

  // Window length in ticks for a select code; 0 means disabled.
  function automatic int unsigned period_ticks(input logic [1:0] sel,
                                               input int unsigned t_long,
                                               input int unsigned t_mid,
                                               input int unsigned t_short);
    case (sel)
      2'b00:   return t_long;
      2'b01:   return t_mid;
      2'b10:   return t_short;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    return max2(max2(a, b), max2(c, d));
  endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  assign tick = (pcnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            pcnt <= '0;
    else if (clr || tick)  pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end

  generate
    if (PRESCALE > 1) begin : g_gap
      // Ticks are never back to back when the prescaler divides.
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wdg_interval.sv
module wdg_interval #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = tick && (limit != '0) && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           cnt <= '0;
    else if (clr || done) cnt <= '0;
    else if (tick)        cnt <= cnt + 1'b1;
  end

  // The tick count stays inside the active window.
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!clr && limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/wdg_cause_flag.sv
module wdg_cause_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!por_n)
    set_i |=> flag);
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!por_n)
    (clr_i && !set_i) |=> !flag);
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!set_i && !clr_i) |=> $stable(flag));

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
  parameter int unsigned PRESCALE  = 4,
  parameter int unsigned T_LONG    = 14,
  parameter int unsigned T_MID     = 6,
  parameter int unsigned T_SHORT   = 2,
  parameter int unsigned RST_TICKS = 3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       kick,
  input  logic [1:0] wd_sel,
  input  logic       flag_set,
  input  logic       flag_clr,
  output logic       rst_out,
  output logic       cause_flag
);
  import wdg_pkg::*;

  localparam int unsigned MAXT = max4(T_LONG, T_MID, T_SHORT, RST_TICKS);
  localparam int unsigned TW   = $clog2(MAXT + 1);

  phase_e        phase;
  logic [1:0]    sel_q;
  logic          tick;
  logic          done;
  logic [TW-1:0] limit;

  // Named internal events
  logic sel_chg;
  logic wd_off;
  logic run_restart;
  logic expire;
  logic pulse_end;
  logic cnt_clr;

  assign sel_chg     = (wd_sel != sel_q);
  assign wd_off      = (wd_sel == SEL_OFF);
  assign run_restart = (phase == PH_RUN) && (kick || sel_chg || wd_off);
  assign expire      = (phase == PH_RUN) && done && !kick && !sel_chg;
  assign pulse_end   = (phase == PH_HOLD) && done;
  assign cnt_clr     = run_restart || expire || pulse_end;

  assign limit = (phase == PH_HOLD) ? TW'(RST_TICKS)
                                    : TW'(period_ticks(wd_sel, T_LONG, T_MID, T_SHORT));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sel_q <= SEL_OFF;
    else        sel_q <= wd_sel;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         phase <= PH_RUN;
    else if (expire)    phase <= PH_HOLD;
    else if (pulse_end) phase <= PH_RUN;
  end

  assign rst_out = (phase == PH_HOLD);

  wdg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .por_n(por_n),
    .clr  (cnt_clr),
    .tick (tick)
  );

  wdg_interval #(.W(TW)) u_ivl (
    .clk  (clk),
    .por_n(por_n),
    .tick (tick),
    .clr  (cnt_clr),
    .limit(limit),
    .done (done)
  );

  wdg_cause_flag u_flag (
    .clk  (clk),
    .por_n(por_n),
    .set_i(flag_set),
    .clr_i(flag_clr),
    .flag (cause_flag)
  );

  p_expire_raises_rst_r2: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> rst_out);
  p_off_no_expire_r3: assert property (@(posedge clk) disable iff (!por_n)
    wd_off |-> !expire);
  p_kick_blocks_expire_r4: assert property (@(posedge clk) disable iff (!por_n)
    (kick && !rst_out) |=> !rst_out);
  p_pulse_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
    (rst_out && !pulse_end) |=> rst_out);
  p_pulse_ends_r7: assert property (@(posedge clk) disable iff (!por_n)
    pulse_end |=> !rst_out);
  p_rst_keeps_flag_r9: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_out) && !$past(flag_set) && !$past(flag_clr)) |-> $stable(cause_flag));

endmodule

// File: tb/sim_wdg_supervisor.sv
module sim_wdg_supervisor;
  localparam int P  = 4;
  localparam int TL = 14;
  localparam int TM = 6;
  localparam int TS = 2;
  localparam int TR = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic kick = 1'b0;
  logic [1:0] wd_sel = 2'b11;
  logic flag_set = 1'b0;
  logic flag_clr = 1'b0;
  logic rst_out;
  logic cause_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wdg_supervisor #(.PRESCALE(P), .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .RST_TICKS(TR)) u0 (
    .clk(clk), .por_n(por_n), .kick(kick), .wd_sel(wd_sel),
    .flag_set(flag_set), .flag_clr(flag_clr),
    .rst_out(rst_out), .cause_flag(cause_flag)
  );

  // {select, expected edges to rise (0 = never)}
  localparam int VEC[4][2] = '{
    '{0, TL * P},
    '{1, TM * P},
    '{2, TS * P},
    '{3, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Counts edges after the restart edge until rst_out is seen high.
  task automatic count_rise(input int lim, output int n);
    n = 0;
    while (!rst_out && n < lim) begin
      step();
      n++;
    end
    if (!rst_out) n = 0;
  endtask

  // Called with rst_out high; returns cycles high.
  task automatic pulse_len(input bit poke, output int h);
    h = 1;
    while (rst_out) begin
      kick = poke && (h == 2);
      if (poke && h == 4) wd_sel = wd_sel ^ 2'b01;
      step();
      kick = 1'b0;
      if (rst_out) h++;
    end
  endtask

  task automatic kick_once();
    kick = 1'b1;
    step();
    kick = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int h;
    repeat (3) step();
    check(rst_out == 1'b0 && cause_flag == 1'b0, "R1 during reset", {rst_out, cause_flag}, 0);
    por_n = 1'b1;
    step();
    check(rst_out == 1'b0 && cause_flag == 1'b0, "R1 after release", {rst_out, cause_flag}, 0);

    // Table walk: R2 windows and R3 disable
    for (int i = 0; i < 4; i++) begin
      wd_sel = 2'(VEC[i][0]);
      kick_once();
      count_rise(3 * TL * P, n);
      check(n == VEC[i][1], (VEC[i][0] == 3) ? "R3 disabled" : "R2 window", n, VEC[i][1]);
      if (rst_out) begin
        pulse_len(1'b0, h);
        check(h == TR * P, "R6 pulse length", h, TR * P);
      end
    end

    // R4: periodic kicks keep the short window from expiring
    wd_sel = 2'b10;
    kick_once();
    for (int k = 0; k < 10; k++) begin
      repeat (TS * P - 3) step();
      kick_once();
    end
    check(rst_out == 1'b0, "R4 kicks hold off", rst_out, 0);
    count_rise(3 * TL * P, n);
    check(n == TS * P, "R4 restart from last kick", n, TS * P);
    pulse_len(1'b0, h);

    // R5: select change restarts with the new window
    wd_sel = 2'b00;
    kick_once();
    repeat (30) step();
    check(rst_out == 1'b0, "R5 no early rise", rst_out, 0);
    wd_sel = 2'b10;
    step();
    count_rise(3 * TL * P, n);
    check(n == TS * P, "R5 select change", n, TS * P);

    // R6: kick and select change during pulse are ignored
    pulse_len(1'b1, h);
    check(h == TR * P, "R6 pulse ignores host", h, TR * P);

    // R7: count resumes from the falling edge (select now 2'b11 ^ ... use short)
    wd_sel = 2'b10;
    kick_once();
    count_rise(3 * TL * P, n);
    pulse_len(1'b0, h);
    count_rise(3 * TL * P, n);
    check(n == TS * P, "R7 resume after pulse", n, TS * P);
    pulse_len(1'b0, h);

    // R8: flag set, clear, both
    wd_sel = 2'b11;
    flag_set = 1'b1; step(); flag_set = 1'b0;
    check(cause_flag == 1'b1, "R8 set", cause_flag, 1);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    check(cause_flag == 1'b0, "R8 clear", cause_flag, 0);
    flag_set = 1'b1; flag_clr = 1'b1; step(); flag_set = 1'b0; flag_clr = 1'b0;
    check(cause_flag == 1'b1, "R8 set wins", cause_flag, 1);

    // R9: watchdog pulse keeps the flag, power-on clears it
    wd_sel = 2'b10;
    kick_once();
    count_rise(3 * TL * P, n);
    check(rst_out == 1'b1 && cause_flag == 1'b1, "R9 flag during pulse", cause_flag, 1);
    pulse_len(1'b0, h);
    check(cause_flag == 1'b1, "R9 flag after pulse", cause_flag, 1);
    por_n = 1'b0;
    step();
    check(cause_flag == 1'b0 && rst_out == 1'b0, "R9 power-on clears", cause_flag, 0);
    wd_sel = 2'b11;
    por_n = 1'b1;
    step();
    check(cause_flag == 1'b0, "R1 flag after power-on", cause_flag, 0);

    finish_run();
  end

endmodule